// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers a set of interrupt request lines and gives each one a 4-bit level. The levels sit in a bank of five 16-bit level registers, and software writes them through a plain address/data/write-enable port. On every cycle the block finds the active request with the highest level and compares that level with the 4-bit mask taken from the CPU status register. When the level is above the mask, the block drives a single request to the CPU. That request carries the accepted level, an 8-bit vector number and a flag that tells whether the source is an external line.

The winner is worked out by combinational logic and captured in one register stage that drives the CPU-facing outputs. Requests that lose stay pending. The block keeps no memory of them, so a request that stays asserted is offered again on later cycles. If a higher request arrives before the CPU acknowledges, it replaces the one being offered. An acknowledge pulls the request low on the next cycle, so the same event is not signalled twice in a row.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After a synchronous reset, cpu_irq, cpu_level, cpu_vector and cpu_ext are all 0, and every level field reads as 0.
- R2: A write with lvl_we=1 and lvl_addr in 0..4 loads lvl_wdata into that register at the clock edge. Register r holds fields 4r..4r+3, and field f sits in bits [4(f%4)+3 : 4(f%4)]. Sources 0..15 use field s. Sources 16..23 use field 16+(s-16)/2, so each pair shares one field.
- R3: A write with lvl_addr in 5..7 changes no level.
- R4: Among the asserted requests, the one with the numerically highest level is the one offered.
- R5: When requests tie on level, including two sources that share one field, the lowest source index wins.
- R6: A source whose level is 0 is never offered to the CPU.
- R7: cpu_irq is raised only when the winning level is strictly greater than cpu_mask. A level equal to or below the mask leaves cpu_irq low.
- R8: The outputs reflect the requests, levels and mask present at the preceding clock edge. A higher request that arrives while a lower one is being offered takes over on the next cycle.
- R9: On the cycle after cpu_ack is sampled high, cpu_irq is low. Offering resumes on the cycle after that.
- R10: While cpu_irq is high, cpu_vector = 0x40 + source index, and cpu_ext is 1 exactly for sources 0..7. While cpu_irq is low, cpu_level, cpu_vector and cpu_ext are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 24 | Request lines, one per source |
| lvl_we | input | 1 | Level register write enable |
| lvl_addr | input | 3 | Level register index |
| lvl_wdata | input | 16 | Level register write data |
| cpu_mask | input | 4 | Current CPU interrupt mask |
| cpu_ack | input | 1 | CPU acknowledge |
| cpu_irq | output | 1 | Request to the CPU |
| cpu_level | output | 4 | Level of the offered request |
| cpu_vector | output | 8 | Vector number of the offered request |
| cpu_ext | output | 1 | Offered source is an external line |

## Verification
Each output is due one clock edge after the inputs that produce it. A level write becomes visible one edge later than that: the edge that stores the write arbitrates with the old levels, so the new level affects the outputs two edges after the write is presented. The bench drives its inputs at the falling edge and computes the expected result from its own copy of the registers, taken before that cycle's write is applied. It then compares the outputs at the next falling edge. An acknowledge is checked on the cycle that follows it, and the cycle after that is checked for resumed offering.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W = 4;
    localparam int VEC_W = 8;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
        logic             ext;
    } win_t;

    // Field used by a source: direct fields first, then pairs share one field.
    function automatic int field_of(input int src, input int n_direct);
        if (src < n_direct)
            return src;
        return n_direct + (src - n_direct) / 2;
    endfunction

endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_REGS       = 5,
    parameter int FIELDS_PER_REG = 4,
    parameter int ADDR_W         = 3,
    localparam int REG_W         = FIELDS_PER_REG * LVL_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [REG_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][REG_W-1:0]  regs
);

    logic addr_ok;
    assign addr_ok = (int'(addr) < NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst)
            regs <= '0;
        else if (we && addr_ok)
            regs[addr] <= wdata;
    end

    // R3: out-of-range writes leave the bank unchanged
    a_r3_bad_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && !addr_ok) |=> $stable(regs));

    // R2: an in-range write lands in the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && addr_ok) |=> regs[$past(addr)] == $past(wdata));

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
#(
    parameter int          NUM_SRC        = 24,
    parameter int          NUM_DIRECT     = 16,
    parameter int          NUM_EXT        = 8,
    parameter int          NUM_REGS       = 5,
    parameter int          FIELDS_PER_REG = 4,
    parameter logic [VEC_W-1:0] VEC_BASE  = 8'h40,
    localparam int         REG_W          = FIELDS_PER_REG * LVL_W,
    localparam int         IDX_W          = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_SRC-1:0]              req,
    input  logic [NUM_REGS-1:0][REG_W-1:0]  regs,
    output win_t                            win,
    output logic [IDX_W-1:0]                win_idx
);

    logic [LVL_W-1:0] src_lvl [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int FLD = field_of(s, NUM_DIRECT);
        localparam int RI  = FLD / FIELDS_PER_REG;
        localparam int FI  = FLD % FIELDS_PER_REG;
        assign src_lvl[s] = regs[RI][FI*LVL_W +: LVL_W];
    end

    // Ascending scan with strict compare: lower index keeps ties, level 0 never wins.
    always_comb begin
        win     = '0;
        win_idx = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (req[s] && (src_lvl[s] > win.level)) begin
                win.valid  = 1'b1;
                win.level  = src_lvl[s];
                win.vector = VEC_BASE + VEC_W'(s);
                win.ext    = (s < NUM_EXT);
                win_idx    = IDX_W'(s);
            end
        end
    end

    // R4: the chosen source is actually requesting
    a_r4_winner_requests: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> req[win_idx]);

    // R6: a chosen source never has level 0
    a_r6_no_zero_winner: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (win.level != '0));

    // R4: no request, no winner
    a_r4_idle_no_winner: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> !win.valid);

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  win_t             win,
    input  logic [LVL_W-1:0] mask,
    input  logic             ack,
    output logic             cpu_irq,
    output logic [LVL_W-1:0] cpu_level,
    output logic [VEC_W-1:0] cpu_vector,
    output logic             cpu_ext
);

    logic accept;
    assign accept = win.valid && (win.level > mask);

    always_ff @(posedge clk) begin
        if (rst || ack || !accept) begin
            cpu_irq    <= 1'b0;
            cpu_level  <= '0;
            cpu_vector <= '0;
            cpu_ext    <= 1'b0;
        end else begin
            cpu_irq    <= 1'b1;
            cpu_level  <= win.level;
            cpu_vector <= win.vector;
            cpu_ext    <= win.ext;
        end
    end

    // R9: acknowledge drops the request on the next cycle
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (rst)
        ack |=> !cpu_irq);

    // R7: an offered level exceeds the mask seen at the capturing edge
    a_r7_above_mask: assert property (@(posedge clk) disable iff (rst)
        (win.valid && !ack) |=> (cpu_irq == ($past(win.level) > $past(mask))));

    // R10: idle outputs are zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !cpu_irq |-> (cpu_level == '0 && cpu_vector == '0 && !cpu_ext));

    // R6: an offered request never carries level 0
    a_r6_offer_nonzero: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (cpu_level != '0));

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int               NUM_SRC        = 24,
    parameter int               NUM_DIRECT     = 16,
    parameter int               NUM_EXT        = 8,
    parameter int               NUM_REGS       = 5,
    parameter int               FIELDS_PER_REG = 4,
    parameter logic [VEC_W-1:0] VEC_BASE       = 8'h40,
    localparam int              ADDR_W         = $clog2(NUM_REGS),
    localparam int              REG_W          = FIELDS_PER_REG * LVL_W,
    localparam int              IDX_W          = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               lvl_we,
    input  logic [ADDR_W-1:0]  lvl_addr,
    input  logic [REG_W-1:0]   lvl_wdata,
    input  logic [LVL_W-1:0]   cpu_mask,
    input  logic               cpu_ack,
    output logic               cpu_irq,
    output logic [LVL_W-1:0]   cpu_level,
    output logic [VEC_W-1:0]   cpu_vector,
    output logic               cpu_ext
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    win_t                           win;
    logic [IDX_W-1:0]               win_idx;

    irq_lvl_regs #(
        .NUM_REGS       (NUM_REGS),
        .FIELDS_PER_REG (FIELDS_PER_REG),
        .ADDR_W         (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (lvl_we),
        .addr  (lvl_addr),
        .wdata (lvl_wdata),
        .regs  (regs)
    );

    irq_select #(
        .NUM_SRC        (NUM_SRC),
        .NUM_DIRECT     (NUM_DIRECT),
        .NUM_EXT        (NUM_EXT),
        .NUM_REGS       (NUM_REGS),
        .FIELDS_PER_REG (FIELDS_PER_REG),
        .VEC_BASE       (VEC_BASE)
    ) u_select (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .regs    (regs),
        .win     (win),
        .win_idx (win_idx)
    );

    irq_cpu_port u_port (
        .clk        (clk),
        .rst        (rst),
        .win        (win),
        .mask       (cpu_mask),
        .ack        (cpu_ack),
        .cpu_irq    (cpu_irq),
        .cpu_level  (cpu_level),
        .cpu_vector (cpu_vector),
        .cpu_ext    (cpu_ext)
    );

endmodule

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;

    localparam int NSRC = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] irq_req = '0;
    logic        lvl_we = 1'b0;
    logic [2:0]  lvl_addr = '0;
    logic [15:0] lvl_wdata = '0;
    logic [3:0]  cpu_mask = '0;
    logic        cpu_ack = 1'b0;
    logic        cpu_irq;
    logic [3:0]  cpu_level;
    logic [7:0]  cpu_vector;
    logic        cpu_ext;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [15:0] mregs [5];

    always #2.5 clk = ~clk;

    irq_prio_arbiter i_irq_prio_arbiter (
        .clk(clk), .rst(rst), .irq_req(irq_req), .lvl_we(lvl_we),
        .lvl_addr(lvl_addr), .lvl_wdata(lvl_wdata), .cpu_mask(cpu_mask),
        .cpu_ack(cpu_ack), .cpu_irq(cpu_irq), .cpu_level(cpu_level),
        .cpu_vector(cpu_vector), .cpu_ext(cpu_ext)
    );

    function automatic logic [3:0] lvl_of(input int s);
        int f;
        f = (s < 16) ? s : 16 + (s - 16) / 2;
        return mregs[f / 4][(f % 4) * 4 +: 4];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One cycle: drive at falling edge, predict, clock, compare at next falling edge.
    task automatic cyc(input logic [23:0] req, input logic we, input logic [2:0] addr,
                       input logic [15:0] data, input logic [3:0] mask,
                       input logic ack, input string tag);
        logic [3:0] bl;
        int bs;
        logic e_irq;
        logic [3:0] e_lvl;
        logic [7:0] e_vec;
        logic e_ext;
        irq_req = req; lvl_we = we; lvl_addr = addr; lvl_wdata = data;
        cpu_mask = mask; cpu_ack = ack;
        bl = 0; bs = -1;
        for (int s = 0; s < NSRC; s++)
            if (req[s] && lvl_of(s) > bl) begin bl = lvl_of(s); bs = s; end
        e_irq = (bs >= 0) && (bl > mask) && !ack;
        e_lvl = e_irq ? bl : 4'd0;
        e_vec = e_irq ? 8'(8'h40 + bs) : 8'd0;
        e_ext = e_irq && (bs < 8);
        @(posedge clk);
        if (we && addr < 5) mregs[addr] = data;
        @(negedge clk);
        checks++;
        if (cpu_irq !== e_irq || cpu_level !== e_lvl || cpu_vector !== e_vec || cpu_ext !== e_ext) begin
            failures++;
            $display("FAIL %s: got irq=%0b lvl=%0d vec=%02h ext=%0b, expected irq=%0b lvl=%0d vec=%02h ext=%0b",
                     tag, cpu_irq, cpu_level, cpu_vector, cpu_ext, e_irq, e_lvl, e_vec, e_ext);
        end
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < 5; r++) mregs[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (cpu_irq !== 0 || cpu_level !== 0 || cpu_vector !== 0 || cpu_ext !== 0) begin
            failures++;
            $display("FAIL R1: got irq=%0b lvl=%0d, expected all zero", cpu_irq, cpu_level);
        end
        // R1: all fields zero, so nothing can be offered
        cyc(24'hFFFFFF, 0, 0, 0, 0, 0, "R1");
        // R2: write reg0 = levels 1,2,3,4 for sources 0..3; new value used one edge later
        cyc(24'h000008, 1, 0, 16'h4321, 0, 0, "R2");
        cyc(24'h000008, 0, 0, 0, 0, 0, "R2");
        // R4: highest level wins
        cyc(24'h00000F, 0, 0, 0, 0, 0, "R4");
        // R5: shared field 19 (sources 22,23) level 7, plus source 2 of level 3
        cyc(24'h000000, 1, 4, 16'h7000, 0, 0, "R5");
        cyc(24'hC00004, 0, 0, 0, 0, 0, "R5");
        // R5: equal levels on distinct fields: source 9 and 12 both 5
        cyc(24'h000000, 1, 2, 16'h0050, 0, 0, "R5");
        cyc(24'h000000, 1, 3, 16'h0005, 0, 0, "R5");
        cyc(24'h001200, 0, 0, 0, 0, 0, "R5");
        // R6: source 10 level 0, alone, mask 0
        cyc(24'h000400, 0, 0, 0, 0, 0, "R6");
        // R7: level 4 with mask 4 stays pending, with mask 3 accepted
        cyc(24'h000008, 0, 0, 0, 4, 0, "R7");
        cyc(24'h000008, 0, 0, 0, 3, 0, "R7");
        cyc(24'h000008, 0, 0, 0, 15, 0, "R7");
        // R8: lower request offered, then a higher one replaces it
        cyc(24'h000002, 0, 0, 0, 0, 0, "R8");
        cyc(24'h00000A, 0, 0, 0, 0, 0, "R8");
        // R9: ack drops, then the pending request returns
        cyc(24'h00000A, 0, 0, 0, 0, 1, "R9");
        cyc(24'h00000A, 0, 0, 0, 0, 0, "R9");
        // R3: out-of-range write must not raise source 10
        cyc(24'h000000, 1, 5, 16'hFFFF, 0, 0, "R3");
        cyc(24'h000000, 1, 7, 16'hFFFF, 0, 0, "R3");
        cyc(24'h000400, 0, 0, 0, 0, 0, "R3");
        // R10: external and internal vectors
        cyc(24'h000001, 0, 0, 0, 0, 0, "R10");
        cyc(24'h800000, 0, 0, 0, 0, 0, "R10");
        // Random mix (R4 R5 R7 R8 R9 R10)
        for (int i = 0; i < 600; i++) begin
            logic [23:0] rq;
            rq = 24'($urandom) & 24'($urandom);
            cyc(rq, ($urandom % 4) == 0, 3'($urandom % 8), 16'($urandom),
                4'($urandom % 16), ($urandom % 5) == 0, "R8-rand");
        end
        finish_run();
    end

endmodule